// File: doc/BRIEF.md
# Host-Controller Mailbox Port Interface

This block bridges an I/O-mapped host bus and a small embedded controller. The host sees a 16-byte port window whose base is picked by a three-bit jumper code. Inside that window it writes command bytes to the controller, reads reply bytes back and polls status. The controller side has a plain strobe interface. Each direction has its own one-byte mailbox with a data-available flag. The flag sets when the producer writes and clears when the consumer takes the byte.

The controller can raise a host interrupt with a one-cycle pulse. A sticky latch holds that request until the host reads the reply-status port. The same read also reports whether a reply byte is waiting.

A reset port lets host software hold the controller and the mailbox flags in reset. Writing a one holds them, and a following write of zero releases them. A bus reset returns every register to its idle state.

Top module: `mbox_bridge`

## Requirements
- R1: `baseSel` values 0 to 5 place the window at 210h + 10h × `baseSel` (210h, 220h, 230h, 240h, 250h, 260h). Values 6 and 7 decode no address. Any access outside the selected 16-byte window has no effect on any register and reads as 00h.
- R2: A host write at base+Ch stores `hostWdata` as the inbound byte. The byte appears on `ctrlRdata`, and `ctrlInFull` is high from the next clock edge. A write while the flag is already set replaces the byte.
- R3: A `ctrlRd` strobe clears `ctrlInFull` at the next edge. If a host write at base+Ch arrives in the same cycle, the write wins and the flag stays set.
- R4: A `ctrlWr` strobe stores `ctrlWdata` as the outbound byte and sets `ctrlOutFull` at the next edge. `ctrlOutFull` is the flag the controller reads back.
- R5: A host read at base+Ah returns the outbound byte on `hostRdata` in the same cycle and clears `ctrlOutFull` at the next edge. If `ctrlWr` is high in the same cycle, the flag stays set.
- R6: A host read at base+Eh returns `ctrlOutFull` on bit 7 with all other bits 0. A host read at base+Ch returns `ctrlInFull` on bit 7 with all other bits 0.
- R7: A `ctrlIrqPulse` sets `irq` at the next edge. `irq` then stays high until a host read at base+Eh, which clears it at the next edge. A pulse in the same cycle as that read wins.
- R8: A host write at base+6h with bit 0 = 1 raises `ctrlReset` at the next edge. At that same edge both flags and `irq` clear. While `ctrlReset` is high, the flags and `irq` are held clear, and host writes at base+Ch, `ctrlWr` and `ctrlIrqPulse` have no effect on any register. A write of bit 0 = 0 at base+6h releases `ctrlReset` at the next edge.
- R9: While `rstBus` is high, at each edge both data bytes go to 00h, and `ctrlInFull`, `ctrlOutFull`, `irq` and `ctrlReset` go to 0.
- R10: `hostRdata` is 00h whenever `hostRd` is low. It is also 00h when the read address is not base+Ah, base+Ch or base+Eh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstBus | input | 1 | Synchronous bus reset, active high |
| baseSel | input | 3 | Jumper code selecting the port window base |
| hostAddr | input | 10 | Host I/O address |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, valid during the `hostRd` cycle |
| ctrlWr | input | 1 | Controller writes the outbound byte |
| ctrlWdata | input | 8 | Outbound byte from the controller |
| ctrlRd | input | 1 | Controller takes the inbound byte |
| ctrlRdata | output | 8 | Inbound byte toward the controller |
| ctrlInFull | output | 1 | Inbound byte waiting for the controller |
| ctrlOutFull | output | 1 | Outbound byte not yet read by the host |
| ctrlIrqPulse | input | 1 | Controller interrupt request pulse |
| irq | output | 1 | Latched host interrupt request |
| ctrlReset | output | 1 | Holds the controller in reset |

## Verification
Host read data is combinational. It is due in the same cycle as the `hostRd` strobe, so the bench compares it shortly after driving the inputs and before the rising edge. Every flag, data byte, `irq` and `ctrlReset` changes exactly one edge after the strobe that causes it. The bench's model therefore advances its state at that edge and compares every registered output at the following falling edge. The same-cycle collisions are driven as single cycles, so the priority order decides the outcome at that one edge: set beats clear, and software reset beats both.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_OUTDATA,
    RD_OUTFLAG,
    RD_INFLAG
  } rdSel_e;

  typedef struct packed {
    logic   loadIn;
    logic   takeIn;
    logic   loadOut;
    logic   takeOut;
    logic   setIrq;
    logic   ackIrq;
    logic   clearAll;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int SEL_W      = 3,
  parameter int WIN_BITS   = 4,
  parameter int BASE_FIRST = 'h210,
  parameter int BASE_STEP  = 'h10,
  parameter int BASE_COUNT = 6,
  parameter int OFS_RST    = 'h6,
  parameter int OFS_RDATA  = 'hA,
  parameter int OFS_WDATA  = 'hC,
  parameter int OFS_STAT   = 'hE
) (
  input  logic              clk,
  input  logic              rstBus,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              rstBit,
  input  logic              ctrlWr,
  input  logic              ctrlRd,
  input  logic              ctrlIrqPulse,
  output logic              softRst,
  output strobes_t          stb
);

  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic [BASE_COUNT-1:0] candHit;
  logic                  inWin;
  logic [WIN_BITS-1:0]   off;
  logic                  atRst, atRdata, atWdata, atStat;
  logic                  rstPortWr;

  // One comparator per jumper position; only the selected one may fire.
  for (genvar g = 0; g < BASE_COUNT; g++) begin : g_cand
    localparam logic [ADDR_W-1:0] CAND = ADDR_W'(BASE_FIRST + g * BASE_STEP);
    assign candHit[g] = (baseSel == SEL_W'(g)) &&
                        (hostAddr[ADDR_W-1:WIN_BITS] == CAND[ADDR_W-1:WIN_BITS]);
  end

  assign inWin   = |candHit;
  assign off     = hostAddr[WIN_BITS-1:0];
  assign atRst   = inWin && (off == WIN_BITS'(OFS_RST));
  assign atRdata = inWin && (off == WIN_BITS'(OFS_RDATA));
  assign atWdata = inWin && (off == WIN_BITS'(OFS_WDATA));
  assign atStat  = inWin && (off == WIN_BITS'(OFS_STAT));

  assign rstPortWr = hostWr && atRst;

  always_ff @(posedge clk) begin
    if (rstBus)         softRst <= 1'b0;
    else if (rstPortWr) softRst <= rstBit;
  end

  always_comb begin
    stb          = '0;
    stb.clearAll = softRst || (rstPortWr && rstBit);
    stb.loadIn   = hostWr && atWdata && !softRst;
    stb.takeIn   = ctrlRd;
    stb.loadOut  = ctrlWr && !softRst;
    stb.takeOut  = hostRd && atRdata;
    stb.setIrq   = ctrlIrqPulse && !softRst;
    stb.ackIrq   = hostRd && atStat;
    stb.rdSel    = RD_NONE;
    if (hostRd) begin
      if (atRdata)      stb.rdSel = RD_OUTDATA;
      else if (atStat)  stb.rdSel = RD_OUTFLAG;
      else if (atWdata) stb.rdSel = RD_INFLAG;
    end
  end

  logic unusedTag;
  assign unusedTag = ^TAG_W;

endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 7
) (
  input  logic              clk,
  input  logic              rstBus,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] ctrlWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] ctrlRdata,
  output logic              inFull,
  output logic              outFull,
  output logic              irqLatch
);

  logic [DATA_W-1:0] inData, outData;

  always_ff @(posedge clk) begin
    if (rstBus) begin
      inData  <= '0;
      outData <= '0;
    end else begin
      if (stb.loadIn)  inData  <= hostWdata;
      if (stb.loadOut) outData <= ctrlWdata;
    end
  end

  // Flag priority: software reset, then set, then clear.
  always_ff @(posedge clk) begin
    if (rstBus || stb.clearAll) begin
      inFull   <= 1'b0;
      outFull  <= 1'b0;
      irqLatch <= 1'b0;
    end else begin
      if (stb.loadIn)       inFull   <= 1'b1;
      else if (stb.takeIn)  inFull   <= 1'b0;
      if (stb.loadOut)      outFull  <= 1'b1;
      else if (stb.takeOut) outFull  <= 1'b0;
      if (stb.setIrq)       irqLatch <= 1'b1;
      else if (stb.ackIrq)  irqLatch <= 1'b0;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_OUTDATA: hostRdata = outData;
      RD_OUTFLAG: hostRdata = DATA_W'(outFull) << FLAG_BIT;
      RD_INFLAG:  hostRdata = DATA_W'(inFull) << FLAG_BIT;
      default:    hostRdata = '0;
    endcase
  end

  assign ctrlRdata = inData;

endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int SEL_W      = 3,
  parameter int WIN_BITS   = 4,
  parameter int BASE_FIRST = 'h210,
  parameter int BASE_STEP  = 'h10,
  parameter int BASE_COUNT = 6,
  parameter int OFS_RST    = 'h6,
  parameter int OFS_RDATA  = 'hA,
  parameter int OFS_WDATA  = 'hC,
  parameter int OFS_STAT   = 'hE,
  parameter int RST_BIT    = 0,
  parameter int FLAG_BIT   = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstBus,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              ctrlWr,
  input  logic [DATA_W-1:0] ctrlWdata,
  input  logic              ctrlRd,
  output logic [DATA_W-1:0] ctrlRdata,
  output logic              ctrlInFull,
  output logic              ctrlOutFull,
  input  logic              ctrlIrqPulse,
  output logic              irq,
  output logic              ctrlReset
);

  strobes_t stb;

  mbox_ctrl #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .WIN_BITS(WIN_BITS),
    .BASE_FIRST(BASE_FIRST), .BASE_STEP(BASE_STEP), .BASE_COUNT(BASE_COUNT),
    .OFS_RST(OFS_RST), .OFS_RDATA(OFS_RDATA), .OFS_WDATA(OFS_WDATA),
    .OFS_STAT(OFS_STAT)
  ) uCtrl (
    .clk(clk), .rstBus(rstBus), .baseSel(baseSel), .hostAddr(hostAddr),
    .hostWr(hostWr), .hostRd(hostRd), .rstBit(hostWdata[RST_BIT]),
    .ctrlWr(ctrlWr), .ctrlRd(ctrlRd), .ctrlIrqPulse(ctrlIrqPulse),
    .softRst(ctrlReset), .stb(stb)
  );

  mbox_dpath #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) uDpath (
    .clk(clk), .rstBus(rstBus), .stb(stb),
    .hostWdata(hostWdata), .ctrlWdata(ctrlWdata),
    .hostRdata(hostRdata), .ctrlRdata(ctrlRdata),
    .inFull(ctrlInFull), .outFull(ctrlOutFull), .irqLatch(irq)
  );

endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int SEL_W      = 3,
  parameter int BASE_FIRST = 'h210,
  parameter int BASE_STEP  = 'h10,
  parameter int BASE_COUNT = 6,
  parameter int OFS_RST    = 'h6,
  parameter int OFS_RDATA  = 'hA,
  parameter int OFS_WDATA  = 'hC,
  parameter int OFS_STAT   = 'hE,
  parameter int FLAG_BIT   = DATA_W - 1
) (
  input logic              clk,
  input logic              rstBus,
  input logic [SEL_W-1:0]  baseSel,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostWr,
  input logic              hostRd,
  input logic              rstBit,
  input logic [DATA_W-1:0] hostRdata,
  input logic              ctrlWr,
  input logic              ctrlRd,
  input logic              ctrlInFull,
  input logic              ctrlOutFull,
  input logic              ctrlIrqPulse,
  input logic              irq,
  input logic              ctrlReset
);

  function automatic logic atOfs(input int o);
    return (int'(baseSel) < BASE_COUNT) &&
           (int'(hostAddr) == BASE_FIRST + int'(baseSel) * BASE_STEP + o);
  endfunction

  logic rstOn, wrIn, rdOut, rdStat;
  assign rstOn  = hostWr && atOfs(OFS_RST) && rstBit;
  assign wrIn   = hostWr && atOfs(OFS_WDATA);
  assign rdOut  = hostRd && atOfs(OFS_RDATA);
  assign rdStat = hostRd && atOfs(OFS_STAT);

  p_inset_r2: assert property (@(posedge clk) disable iff (rstBus)
    wrIn && !ctrlReset && !rstOn |=> ctrlInFull);

  p_inclr_r3: assert property (@(posedge clk) disable iff (rstBus)
    ctrlRd && !wrIn |=> !ctrlInFull);

  p_outset_r4: assert property (@(posedge clk) disable iff (rstBus)
    ctrlWr && !ctrlReset && !rstOn |=> ctrlOutFull);

  p_outclr_r5: assert property (@(posedge clk) disable iff (rstBus)
    rdOut && !ctrlWr |=> !ctrlOutFull);

  p_status_r6: assert property (@(posedge clk) disable iff (rstBus)
    rdStat |-> hostRdata == (DATA_W'(ctrlOutFull) << FLAG_BIT));

  p_irqset_r7: assert property (@(posedge clk) disable iff (rstBus)
    ctrlIrqPulse && !ctrlReset && !rstOn |=> irq);

  p_irqhold_r7: assert property (@(posedge clk) disable iff (rstBus)
    irq && !rdStat && !rstOn |=> irq);

  p_quiet_r8: assert property (@(posedge clk) disable iff (rstBus)
    ctrlReset |-> !irq && !ctrlInFull && !ctrlOutFull);

  p_idle_r10: assert property (@(posedge clk) disable iff (rstBus)
    !hostRd |-> hostRdata == '0);

endmodule

bind mbox_bridge mbox_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
  .BASE_FIRST(BASE_FIRST), .BASE_STEP(BASE_STEP), .BASE_COUNT(BASE_COUNT),
  .OFS_RST(OFS_RST), .OFS_RDATA(OFS_RDATA), .OFS_WDATA(OFS_WDATA),
  .OFS_STAT(OFS_STAT), .FLAG_BIT(FLAG_BIT)
) uChk (
  .clk(clk), .rstBus(rstBus), .baseSel(baseSel), .hostAddr(hostAddr),
  .hostWr(hostWr), .hostRd(hostRd), .rstBit(hostWdata[RST_BIT]),
  .hostRdata(hostRdata), .ctrlWr(ctrlWr), .ctrlRd(ctrlRd),
  .ctrlInFull(ctrlInFull), .ctrlOutFull(ctrlOutFull),
  .ctrlIrqPulse(ctrlIrqPulse), .irq(irq), .ctrlReset(ctrlReset)
);

// File: tb/sim_mbox_bridge.sv
`timescale 1ns/1ps
module sim_mbox_bridge;

  logic       clk = 1'b0;
  logic       rstBus = 1'b1;
  logic [2:0] baseSel = 3'd1;
  logic [9:0] hostAddr = '0;
  logic       hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       ctrlWr = 1'b0;
  logic [7:0] ctrlWdata = '0;
  logic       ctrlRd = 1'b0;
  logic [7:0] ctrlRdata;
  logic       ctrlInFull, ctrlOutFull;
  logic       ctrlIrqPulse = 1'b0;
  logic       irq, ctrlReset;

  always #2 clk = ~clk;

  mbox_bridge u0 (.*);

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // Behavioural model state
  int mIn = 0, mOut = 0;
  bit mInF = 0, mOutF = 0, mIrq = 0, mRst = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit hitAt(input int o);
    return (int'(baseSel) <= 5) && (int'(hostAddr) == 'h210 + 'h10 * int'(baseSel) + o);
  endfunction

  task automatic checkRegs(input string tag);
    chk(tag, "ctrlRdata", ctrlRdata, mIn);
    chk(tag, "ctrlInFull", ctrlInFull, mInF);
    chk(tag, "ctrlOutFull", ctrlOutFull, mOutF);
    chk(tag, "irq", irq, mIrq);
    chk(tag, "ctrlReset", ctrlReset, mRst);
  endtask

  // One bus cycle: drive at negedge, check read data, model the edge, check registers.
  task automatic cyc(input string tag, input bit wr, input bit rd, input int addr,
                     input int wd, input bit cwr, input int cwd, input bit crd, input bit pulse);
    int expRd;
    bit wrIn, rdOut, rdStat, rdIn, rstWr, clr;
    hostWr = wr; hostRd = rd; hostAddr = 10'(addr); hostWdata = 8'(wd);
    ctrlWr = cwr; ctrlWdata = 8'(cwd); ctrlRd = crd; ctrlIrqPulse = pulse;
    #1;
    rdOut  = rd && hitAt('hA);
    rdStat = rd && hitAt('hE);
    rdIn   = rd && hitAt('hC);
    expRd  = rdOut ? mOut : rdStat ? (int'(mOutF) << 7) : rdIn ? (int'(mInF) << 7) : 0;
    chk(tag, "hostRdata", hostRdata, expRd);
    @(posedge clk);
    wrIn  = wr && hitAt('hC) && !mRst;
    rstWr = wr && hitAt('h6);
    clr   = mRst || (rstWr && wd[0]);
    if (wrIn) mIn = wd & 'hFF;
    if (cwr && !mRst) mOut = cwd & 'hFF;
    if (clr) begin
      mInF = 0; mOutF = 0; mIrq = 0;
    end else begin
      if (wrIn) mInF = 1; else if (crd) mInF = 0;
      if (cwr) mOutF = 1; else if (rdOut) mOutF = 0;
      if (pulse) mIrq = 1; else if (rdStat) mIrq = 0;
    end
    if (rstWr) mRst = wd[0];
    @(negedge clk);
    checkRegs(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic hw(input string tag, input int addr, input int d);
    cyc(tag, 1, 0, addr, d, 0, 0, 0, 0);
  endtask

  task automatic hr(input string tag, input int addr);
    cyc(tag, 0, 1, addr, 0, 0, 0, 0, 0);
  endtask

  task automatic busReset(input string tag);
    rstBus = 1'b1;
    hostWr = 0; hostRd = 0; ctrlWr = 0; ctrlRd = 0; ctrlIrqPulse = 0;
    repeat (2) @(posedge clk);
    mIn = 0; mOut = 0; mInF = 0; mOutF = 0; mIrq = 0; mRst = 0;
    @(negedge clk);
    rstBus = 1'b0;
    checkRegs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    busReset("R9 reset state");

    // Inbound mailbox at base 220h
    hw("R2 load", 'h22C, 'h5A);
    hr("R6 in flag", 'h22C);
    cyc("R3 take", 0, 0, 0, 0, 0, 0, 1, 0);
    hr("R6 in flag clear", 'h22C);
    hw("R2 first", 'h22C, 'h11);
    hw("R2 overwrite", 'h22C, 'h22);
    cyc("R3 write wins", 1, 0, 'h22C, 'h33, 0, 0, 1, 0);
    cyc("R3 take after", 0, 0, 0, 0, 0, 0, 1, 0);

    // Outbound mailbox
    cyc("R4 load", 0, 0, 0, 0, 1, 'hC3, 0, 0);
    hr("R6 out flag", 'h22E);
    hr("R5 take", 'h22A);
    hr("R6 out flag clear", 'h22E);
    cyc("R4 reload", 0, 0, 0, 0, 1, 'h44, 0, 0);
    cyc("R5 write wins", 0, 1, 'h22A, 0, 1, 'h55, 0, 0);
    hr("R5 take new", 'h22A);

    // Interrupt latch
    cyc("R7 pulse", 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R7 hold", 3);
    hr("R7 unrelated read keeps", 'h22A);
    hr("R7 ack", 'h22E);
    cyc("R7 pulse", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R7 pulse wins ack", 0, 1, 'h22E, 0, 0, 0, 0, 1);
    hr("R7 ack again", 'h22E);

    // Decode
    hw("R1 other window", 'h21C, 'hA1);
    hw("R1 window 230h", 'h23C, 'hA2);
    hr("R1 outside read", 'h21E);
    baseSel = 3'd0; hw("R1 base 210h", 'h21C, 'h77);
    cyc("R1 take", 0, 0, 0, 0, 0, 0, 1, 0);
    baseSel = 3'd5; hw("R1 base 260h", 'h26C, 'h66);
    baseSel = 3'd6; hw("R1 sel6 none", 'h27C, 'h99);
    hw("R1 sel6 none", 'h26C, 'h98);
    baseSel = 3'd7; hw("R1 sel7 none", 'h28C, 'h97);
    baseSel = 3'd1;
    cyc("R1 take", 0, 0, 0, 0, 0, 0, 1, 0);

    // Idle read data
    cyc("R10 unused offset", 0, 1, 'h221, 0, 0, 0, 0, 0);
    cyc("R10 reset port read", 0, 1, 'h226, 0, 0, 0, 0, 0);
    cyc("R10 no strobe", 0, 0, 'h22A, 0, 0, 0, 0, 0);

    // Software reset
    cyc("R8 setup", 1, 0, 'h22C, 'h3E, 1, 'hE3, 0, 1);
    hw("R8 assert", 'h226, 1);
    hw("R8 data write ignored", 'h22C, 'hBB);
    cyc("R8 ctrl write ignored", 0, 0, 0, 0, 1, 'hCC, 0, 0);
    cyc("R8 pulse ignored", 0, 0, 0, 0, 0, 0, 0, 1);
    hr("R8 flag read", 'h22E);
    hw("R8 release", 'h226, 0);
    hr("R8 old out byte", 'h22A);
    cyc("R8 normal again", 0, 0, 0, 0, 1, 'h5C, 0, 1);
    cyc("R8 reset with activity", 1, 0, 'h226, 1, 1, 'h12, 0, 1);
    hw("R8 release", 'h226, 0);

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      int a;
      case ($urandom_range(0, 5))
        0: a = 'h22A; 1: a = 'h22C; 2: a = 'h22E; 3: a = 'h226; 4: a = 'h23C; default: a = 'h220;
      endcase
      cyc("R2 mixed traffic", $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, a,
          (a == 'h226) ? ($urandom_range(0, 5) == 0) : $urandom_range(0, 255),
          $urandom_range(0, 2) == 0, $urandom_range(0, 255),
          $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0);
    end

    cyc("R9 prep", 1, 0, 'h22C, 'h81, 1, 'h82, 0, 1);
    busReset("R9 bus reset clears");
    hr("R9 out byte zero", 'h22A);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule